// File: doc/BRIEF.md
# Polar Code Belief-Propagation Butterfly Element

This block is the arithmetic core of one butterfly in a belief-propagation decoder for polar codes. A butterfly links two node pairs. On one side it sees two messages that travel toward the source bits, taken from the next stage. On the other side it sees two messages that travel toward the code bits, taken from the current stage. From these four inputs it computes four new messages, two for each direction. All of them come from one pairwise combining function, which is a scaled min-sum stand-in for the log-cosh box-plus, together with saturating additions.

Every message is an 8-bit two's complement log-likelihood ratio by default, and the width is a parameter. The surrounding decoder keeps the message memory and decides the stage schedule. It presents one set of four messages with a valid strobe. The element returns the four results from registers one cycle later, with its own valid strobe. Between strobes the output registers keep their values.

Top module: `polar_bp_pe`

## Requirements
- R1: The combining function g(x,y) has magnitude s = m - (m>>3) + (m>>5), where m = min(|x|,|y|). The shifts are taken on the magnitude, so the result rounds toward zero. g is negative exactly when one operand is negative, and it is 0 when either operand is 0.
- R2: `toleft_up` = g(`nxt_up`, sat(`nxt_lo` + `cur_lo`)).
- R3: `toleft_lo` = sat(g(`cur_up`, `nxt_up`) + `nxt_lo`).
- R4: `toright_up` = g(`cur_up`, sat(`nxt_lo` + `cur_lo`)).
- R5: `toright_lo` = sat(g(`cur_up`, `nxt_up`) + `cur_lo`).
- R6: Each sum sat(a+b) is clamped to [-127, +127]. No output ever carries -128 (8'h80).
- R7: An input of -128 is handled as -127 before any arithmetic.
- R8: `out_valid` is high in the cycle after an `in_valid` cycle and low otherwise. The outputs load only when `in_valid` is high and hold their value in every other cycle.
- R9: While `rst` is high at a clock edge, all four outputs are cleared to 0 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The four input messages are valid this cycle |
| nxt_up | input | 8 | Upper message from the next stage, travelling toward the source side |
| nxt_lo | input | 8 | Lower message from the next stage, travelling toward the source side |
| cur_up | input | 8 | Upper message at this stage, travelling toward the code side |
| cur_lo | input | 8 | Lower message at this stage, travelling toward the code side |
| out_valid | output | 1 | The result registers were loaded on the last edge |
| toleft_up | output | 8 | New upper message toward the source side |
| toleft_lo | output | 8 | New lower message toward the source side |
| toright_up | output | 8 | New upper message toward the code side |
| toright_lo | output | 8 | New lower message toward the code side |

## Verification
The assertions check the following on every cycle: the one-cycle strobe relation, that outputs hold while idle, that -128 never appears, and the degenerate cases where a zero operand forces g to 0 so that an output simply repeats an input. The exact scaled magnitudes, the rounding toward zero and the clamping of sums only show up in the bench's vectors. These include hand-computed cases at full scale, mixed signs and -128 inputs, plus a sweep against a model built from the requirements.

// File: rtl/polar_pe_pkg.sv
package polar_pe_pkg;
  localparam int MSG_W_DEF = 8;
  localparam int SCALE_SH_A = 3;
  localparam int SCALE_SH_B = 5;
  localparam int PORTS_IN = 4;
endpackage

// File: rtl/pe_input_clamp.sv
module pe_input_clamp #(
  parameter int W = polar_pe_pkg::MSG_W_DEF
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SYM_NEG  = {1'b1, {(W-2){1'b0}}, 1'b1};

  always_comb begin
    if (din == MOST_NEG) dout = SYM_NEG;
    else                 dout = din;
  end
endmodule

// File: rtl/pe_sat_add.sv
module pe_sat_add #(
  parameter int W = polar_pe_pkg::MSG_W_DEF
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic signed [W:0] POS_LIM = (W+1)'((2 ** (W-1)) - 1);
  localparam logic signed [W:0] NEG_LIM = -POS_LIM;

  logic signed [W:0] sum_w;

  always_comb begin
    sum_w = $signed({a[W-1], a}) + $signed({b[W-1], b});
    if (sum_w > POS_LIM)      y = POS_LIM[W-1:0];
    else if (sum_w < NEG_LIM) y = NEG_LIM[W-1:0];
    else                      y = sum_w[W-1:0];
  end
endmodule

// File: rtl/pe_minsum.sv
module pe_minsum #(
  parameter int W  = polar_pe_pkg::MSG_W_DEF,
  parameter int SA = polar_pe_pkg::SCALE_SH_A,
  parameter int SB = polar_pe_pkg::SCALE_SH_B
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] g
);
  logic [W-1:0] mag_x, mag_y, mag_min, mag_scl;
  logic         neg;

  always_comb begin
    mag_x   = x[W-1] ? (~x + 1'b1) : x;
    mag_y   = y[W-1] ? (~y + 1'b1) : y;
    mag_min = (mag_x < mag_y) ? mag_x : mag_y;
    // magnitude * ~0.906, truncating each shift toward zero
    mag_scl = mag_min - (mag_min >> SA) + (mag_min >> SB);
    neg     = x[W-1] ^ y[W-1];
    g       = neg ? (~mag_scl + 1'b1) : mag_scl;
  end
endmodule

// File: rtl/polar_bp_pe.sv
module polar_bp_pe #(
  parameter int W = polar_pe_pkg::MSG_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] nxt_up,
  input  logic [W-1:0] nxt_lo,
  input  logic [W-1:0] cur_up,
  input  logic [W-1:0] cur_lo,
  output logic         out_valid,
  output logic [W-1:0] toleft_up,
  output logic [W-1:0] toleft_lo,
  output logic [W-1:0] toright_up,
  output logic [W-1:0] toright_lo
);
  localparam int NIN = polar_pe_pkg::PORTS_IN;

  logic [W-1:0] raw_in [NIN];
  logic [W-1:0] cln_in [NIN];

  assign raw_in[0] = nxt_up;
  assign raw_in[1] = nxt_lo;
  assign raw_in[2] = cur_up;
  assign raw_in[3] = cur_lo;

  for (genvar k = 0; k < NIN; k++) begin : g_clamp
    pe_input_clamp #(.W(W)) u_clamp (.din(raw_in[k]), .dout(cln_in[k]));
  end

  logic [W-1:0] lo_pair_sum;
  logic [W-1:0] g_up_pair;
  logic [W-1:0] nx_left_up, nx_left_lo, nx_right_up, nx_right_lo;

  pe_sat_add #(.W(W)) u_lo_sum (.a(cln_in[1]), .b(cln_in[3]), .y(lo_pair_sum));

  pe_minsum #(.W(W)) u_g_up   (.x(cln_in[2]), .y(cln_in[0]), .g(g_up_pair));
  pe_minsum #(.W(W)) u_g_left (.x(cln_in[0]), .y(lo_pair_sum), .g(nx_left_up));
  pe_minsum #(.W(W)) u_g_rght (.x(cln_in[2]), .y(lo_pair_sum), .g(nx_right_up));

  pe_sat_add #(.W(W)) u_left_lo  (.a(g_up_pair), .b(cln_in[1]), .y(nx_left_lo));
  pe_sat_add #(.W(W)) u_right_lo (.a(g_up_pair), .b(cln_in[3]), .y(nx_right_lo));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      toleft_up  <= '0;
      toleft_lo  <= '0;
      toright_up <= '0;
      toright_lo <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        toleft_up  <= nx_left_up;
        toleft_lo  <= nx_left_lo;
        toright_up <= nx_right_up;
        toright_lo <= nx_right_lo;
      end
    end
  end
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int W = polar_pe_pkg::MSG_W_DEF
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] nxt_up,
  input logic [W-1:0] nxt_lo,
  input logic [W-1:0] cur_up,
  input logic [W-1:0] cur_lo,
  input logic         out_valid,
  input logic [W-1:0] toleft_up,
  input logic [W-1:0] toleft_lo,
  input logic [W-1:0] toright_up,
  input logic [W-1:0] toright_lo
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(toleft_up) && $stable(toleft_lo) &&
                   $stable(toright_up) && $stable(toright_lo)));
  a_r6_no_most_neg: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (toleft_up != MOST_NEG && toleft_lo != MOST_NEG &&
                   toright_up != MOST_NEG && toright_lo != MOST_NEG));
  a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nxt_up == '0) |=> toleft_up == '0);
  a_r5_zero_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_up == '0 && cur_lo != MOST_NEG) |=>
      (toright_up == '0 && toright_lo == $past(cur_lo)));
  a_r3_zero_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nxt_up == '0 && nxt_lo != MOST_NEG) |=>
      toleft_lo == $past(nxt_lo));
endmodule

bind polar_bp_pe pe_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .nxt_up(nxt_up), .nxt_lo(nxt_lo), .cur_up(cur_up), .cur_lo(cur_lo),
  .out_valid(out_valid), .toleft_up(toleft_up), .toleft_lo(toleft_lo),
  .toright_up(toright_up), .toright_lo(toright_lo)
);

// File: tb/sim_polar_bp_pe.sv
module sim_polar_bp_pe;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {nxt_up, nxt_lo, cur_up, cur_lo, exp toleft_up, toleft_lo, toright_up, toright_lo}
  localparam int VEC [NV][8] = '{
    '{  10,   20,   30,   40,   9,   29,   27,   49},
    '{ -50,   20,   64,   -5, -14,  -25,   14,  -50},
    '{ 100,  100,  100,  100,  91,  127,   91,  127},
    '{-100, -100,  100, -100,  91, -127,  -91, -127},
    '{   0,    7,   -9,    3,   0,    7,   -8,    3},
    '{-128,    0, -128,    0,   0,  115,    0,  115}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] nxt_up = '0, nxt_lo = '0, cur_up = '0, cur_lo = '0;
  logic out_valid;
  logic [7:0] toleft_up, toleft_lo, toright_up, toright_lo;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  polar_bp_pe u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .nxt_up(nxt_up), .nxt_lo(nxt_lo), .cur_up(cur_up), .cur_lo(cur_lo),
    .out_valid(out_valid), .toleft_up(toleft_up), .toleft_lo(toleft_lo),
    .toright_up(toright_up), .toright_lo(toright_lo)
  );

  function automatic int clip(int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  function automatic int gmod(int x, int y);
    int ax, ay, m, s;
    ax = (x < 0) ? -x : x;
    ay = (y < 0) ? -y : y;
    m  = (ax < ay) ? ax : ay;
    s  = m - (m / 8) + (m / 32);
    return ((x < 0) != (y < 0)) ? -s : s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(int a, int b, int c, int d);
    @(negedge clk);
    nxt_up = 8'(a); nxt_lo = 8'(b); cur_up = 8'(c); cur_lo = 8'(d);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 toleft_up", int'($signed(toleft_up)), 0);
    check("R9 toright_lo", int'($signed(toright_lo)), 0);
    rst = 1'b0;

    // Table: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      check("R8 out_valid", int'(out_valid), 1);
      check("R2 toleft_up", int'($signed(toleft_up)), VEC[i][4]);
      check("R3 toleft_lo", int'($signed(toleft_lo)), VEC[i][5]);
      check("R4 toright_up", int'($signed(toright_up)), VEC[i][6]);
      check("R5 toright_lo", int'($signed(toright_lo)), VEC[i][7]);
    end

    // R8: idle cycle with new inputs: no strobe, outputs held (last vector: 0,115,0,115)
    @(negedge clk);
    nxt_up = 8'(55); nxt_lo = 8'(-33); cur_up = 8'(12); cur_lo = 8'(90);
    @(negedge clk);
    check("R8 idle out_valid", int'(out_valid), 0);
    check("R8 hold toleft_lo", int'($signed(toleft_lo)), 115);
    check("R8 hold toright_lo", int'($signed(toright_lo)), 115);

    // R1 rounding: m=31 -> 31-3+0=28, m=7 -> 7-0+0=7
    apply(31, 0, 31, 0);
    check("R1 scale 31", int'($signed(toleft_up)), 0);
    check("R1 scale 31 toleft_lo", int'($signed(toleft_lo)), 28);
    apply(-7, 0, 7, 0);
    check("R1 scale -7 sign", int'($signed(toleft_lo)), -7);

    // R6 sweep against a requirement model; no -128 anywhere
    for (int k = 0; k < 40; k++) begin
      int a, b, c, d, s1, gu;
      a = ((k * 37) % 256) - 128;
      b = ((k * 91 + 17) % 256) - 128;
      c = ((k * 53 + 101) % 256) - 128;
      d = ((k * 29 + 200) % 256) - 128;
      apply(a, b, c, d);
      if (a == -128) a = -127;
      if (b == -128) b = -127;
      if (c == -128) c = -127;
      if (d == -128) d = -127;
      s1 = clip(b + d);
      gu = gmod(c, a);
      check("R2 sweep", int'($signed(toleft_up)), gmod(a, s1));
      check("R3 sweep", int'($signed(toleft_lo)), clip(gu + b));
      check("R4 sweep", int'($signed(toright_up)), gmod(c, s1));
      check("R5 sweep", int'($signed(toright_lo)), clip(gu + d));
      check("R6 no -128", int'(toleft_lo == 8'h80 || toright_lo == 8'h80), 0);
    end

    // R9: reset mid-run clears registers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset toleft_lo", int'($signed(toleft_lo)), 0);
    check("R9 reset out_valid", int'(out_valid), 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule